// File: doc/BRIEF.md
# Blanking-Window Control Session Controller

This block sits on the receive side of a serial video link and shares that link with a low-rate control session. While video runs, it passes the pixel data, the line sync and the frame sync through one register stage. On the selected edge of the frame sync it closes the video window and opens a control window. A control-enable output tells the host that the window is open. For as long as the window stays open, the line sync and the pixel data are frozen at their last values. The pixel clock and the frame sync path keep running.

Inside the window the host sends asynchronous serial bytes. The frame is a low start bit, eight data bits with the least significant bit first, an even-parity bit and a high stop bit. Each byte that arrives intact is presented to the downstream decoder as a one-cycle strobe. The window closes in three cases: the host sends the all-ones end byte, no byte arrives within the start window, or no further byte arrives within the end window. Both windows count a pixel clock divided by a programmable ratio. A sticky two-bit error register records bad parity and bad stop bits. The register clears on a read strobe and pulls an active-low error line while any bit is set.

Top module: `ctlwin_ctrl`

## Requirements
- R1: After reset `ctl_en` is 0, `err_n` is 1, `err_flags` is 0, `rx_valid` is 0 and `vid_out` and `hsync_out` are 0.
- R2: With `vsync_rise`=0 a falling edge of `vsync_in` opens the window: `ctl_en` is high in the cycle after the edge is sampled. A rising edge does not open it.
- R3: With `vsync_rise`=1 a rising edge of `vsync_in` opens the window and a falling edge does not.
- R4: While the window is open, `vid_out` and `hsync_out` keep the values loaded on the entry edge, even if the inputs change. `vsync_out` always follows `vsync_in` one cycle later, in both phases.
- R5: A frame on `uart_rx` has each bit held for BIT_CLKS clocks: one low start bit, data bit 0 first up to bit 7, one even-parity bit (so that the nine bits have an even count of ones), and one high stop bit. A frame with correct parity and a high stop bit that arrives while the window is open produces one `rx_valid` pulse with the byte on `rx_data`.
- R6: An intact byte 8'hFF closes the window. `ctl_en` is low in the same cycle as its `rx_valid` pulse.
- R7: When no frame arrives, `ctl_en` stays high for exactly (`sto_val`+1)·(`div_sel`+1) cycles.
- R8: Any received frame, intact or not, restarts the timeout. From the `rx_valid` cycle of the last byte, `ctl_en` stays high for exactly `eto_val`·(`div_sel`+1) cycles.
- R9: A frame with wrong parity produces no `rx_valid` and sets `err_flags[0]`. Even with 8'hFF data, such a frame leaves the window open.
- R10: A frame with a low stop bit produces no `rx_valid` and sets `err_flags[1]`.
- R11: `err_n` is low while any `err_flags` bit is set. A one-cycle `err_rd` pulse clears `err_flags`, and `err_n` then returns high.
- R12: Frames that arrive while the window is closed produce no `rx_valid` and set no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_rise | input | 1 | 1: rising frame-sync edge opens the window; 0: falling |
| div_sel | input | DIV_W | Timeout prescaler; ratio is div_sel+1 |
| sto_val | input | CNT_W | Start window length minus one, in divided ticks |
| eto_val | input | CNT_W | End window length in divided ticks |
| vsync_in | input | 1 | Frame sync from the link |
| hsync_in | input | 1 | Line sync from the link |
| vid_in | input | DATA_W | Pixel data from the link |
| uart_rx | input | 1 | Host serial line, idle high |
| err_rd | input | 1 | Read strobe that clears the error register |
| vsync_out | output | 1 | Registered frame sync |
| hsync_out | output | 1 | Registered line sync, frozen in the window |
| vid_out | output | DATA_W | Registered pixel data, frozen in the window |
| ctl_en | output | 1 | High while the control window is open |
| rx_data | output | 8 | Last intact byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| err_flags | output | 2 | Bit 0 parity error, bit 1 stop-bit error |
| err_n | output | 1 | Low while any error flag is set |

## Verification
The assertions assume that `vsync_in` is high when reset is released, so that no false falling edge is seen. They also assume that `err_rd` is low during reset and that the timeout fields do not change while a window is open. The bench meets these conditions: it holds the frame sync high through reset, and it writes the divider and both window fields only while `ctl_en` is low. Serial frames are driven at exactly BIT_CLKS clocks per bit. A whole frame is sent before the next one starts, and every byte in a long session lands well inside the end window.

// File: rtl/ctlwin_pkg.sv
package ctlwin_pkg;
   typedef enum logic {PH_VIDEO, PH_CTRL} phase_t;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;
   localparam logic [7:0] END_BYTE = 8'hFF;
endpackage

// File: rtl/ctlwin_uart_rx.sv
module ctlwin_uart_rx
   import ctlwin_pkg::*;
#(
   parameter int BIT_CLKS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx,
   output logic       done,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr
);
   localparam int CW   = $clog2(BIT_CLKS);
   localparam int HALF = BIT_CLKS / 2;

   if (BIT_CLKS < 4) begin : g_bad_bit
      $error("BIT_CLKS must be at least 4");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
      $error("SYNC_STAGES must be 1 or 2");
   end

   logic rxs;
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) rxs <= 1'b1;
         else        rxs <= rx;
   end else begin : g_sync2
      logic meta_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            meta_q <= 1'b1;
            rxs    <= 1'b1;
         end else begin
            meta_q <= rx;
            rxs    <= meta_q;
         end
   end

   rx_st_t       st;
   logic [CW-1:0] tcnt;
   logic [3:0]    bidx;
   logic [9:0]    sh, sh_nx;

   always_comb sh_nx = {rxs, sh[9:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         tcnt <= '0;
         bidx <= '0;
         sh   <= '0;
         done <= 1'b0;
         data <= '0;
         perr <= 1'b0;
         ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            RX_IDLE: begin
               tcnt <= '0;
               if (!rxs) st <= RX_START;
            end
            RX_START: begin
               if (tcnt == CW'(HALF - 1)) begin
                  tcnt <= '0;
                  bidx <= '0;
                  st   <= rxs ? RX_IDLE : RX_BITS;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_BITS: begin
               if (tcnt == CW'(BIT_CLKS - 1)) begin
                  tcnt <= '0;
                  sh   <= sh_nx;
                  if (bidx == 4'd9) begin
                     done <= 1'b1;
                     data <= sh_nx[7:0];
                     perr <= ^sh_nx[8:0];
                     ferr <= ~sh_nx[9];
                     st   <= RX_IDLE;
                  end else begin
                     bidx <= bidx + 1'b1;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   // a frame takes many cycles, so completion is never back to back
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/ctlwin_timeout.sv
module ctlwin_timeout #(
   parameter int DIV_W = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [CNT_W-1:0] sto_val,
   input  logic [CNT_W-1:0] eto_val,
   output logic             expire
);
   localparam int LIM_W = CNT_W + 1;

   if (DIV_W < 1 || CNT_W < 1) begin : g_bad_w
      $error("timeout widths must be positive");
   end

   logic [DIV_W-1:0] pre;
   logic [LIM_W-1:0] cnt, limit;
   logic             armed, tick;

   always_comb begin
      tick   = run && (pre == div_sel);
      limit  = armed ? LIM_W'(eto_val) : LIM_W'(sto_val) + LIM_W'(1);
      expire = tick && !kick && ((cnt + LIM_W'(1)) >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre   <= '0;
         cnt   <= '0;
         armed <= 1'b0;
      end else begin
         if (!run || kick) begin
            pre <= '0;
            cnt <= '0;
         end else if (tick) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
         if (!run)      armed <= 1'b0;
         else if (kick) armed <= 1'b1;
      end
   end

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < limit || cnt == '0));
   assert_kick_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt == '0 && pre == '0));
endmodule

// File: rtl/ctlwin_ctrl.sv
module ctlwin_ctrl
   import ctlwin_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int BIT_CLKS    = 8,
   parameter int DIV_W       = 4,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_rise,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic [CNT_W-1:0]  sto_val,
   input  logic [CNT_W-1:0]  eto_val,
   input  logic              vsync_in,
   input  logic              hsync_in,
   input  logic [DATA_W-1:0] vid_in,
   input  logic              uart_rx,
   input  logic              err_rd,
   output logic              vsync_out,
   output logic              hsync_out,
   output logic [DATA_W-1:0] vid_out,
   output logic              ctl_en,
   output logic [7:0]        rx_data,
   output logic              rx_valid,
   output logic [1:0]        err_flags,
   output logic              err_n
);
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   phase_t     ph;
   logic       vs_d, vs_edge, fr_done, fr_perr, fr_ferr, fr_good, expire;
   logic [7:0] fr_data;
   logic [1:0] err_nx;

   ctlwin_uart_rx #(.BIT_CLKS(BIT_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx(uart_rx),
      .done(fr_done), .data(fr_data), .perr(fr_perr), .ferr(fr_ferr));

   ctlwin_timeout #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .run(ph == PH_CTRL), .kick(fr_done),
      .div_sel(div_sel), .sto_val(sto_val), .eto_val(eto_val), .expire(expire));

   always_comb begin
      vs_edge = vsync_rise ? (vsync_in && !vs_d) : (!vsync_in && vs_d);
      fr_good = fr_done && !fr_perr && !fr_ferr;
      err_nx  = err_rd ? 2'b00 : err_flags;
      if (ph == PH_CTRL && fr_done) err_nx = err_nx | {fr_ferr, fr_perr};
      ctl_en  = (ph == PH_CTRL);
      err_n   = ~|err_flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_VIDEO;
         vs_d      <= 1'b1;
         vsync_out <= 1'b1;
         hsync_out <= 1'b0;
         vid_out   <= '0;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
         err_flags <= '0;
      end else begin
         vs_d      <= vsync_in;
         vsync_out <= vsync_in;
         err_flags <= err_nx;
         rx_valid  <= 1'b0;
         if (ph == PH_VIDEO) begin
            hsync_out <= hsync_in;
            vid_out   <= vid_in;
            if (vs_edge) ph <= PH_CTRL;
         end else begin
            if (fr_good) begin
               rx_valid <= 1'b1;
               rx_data  <= fr_data;
            end
            if ((fr_good && fr_data == END_BYTE) || expire) ph <= PH_VIDEO;
         end
      end
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && $past(ctl_en)) |-> ($stable(vid_out) && $stable(hsync_out)));
   assert_no_rx_closed_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(ctl_en));
   assert_perr_in_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[0]) |-> $past(ctl_en));
   assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_rd) && !$past(fr_done)) |-> (err_flags == 2'b00 && err_n));
endmodule

// File: tb/test_ctlwin_ctrl.sv
module test_ctlwin_ctrl;
   localparam int CLK_P    = 10;
   localparam int DATA_W   = 18;
   localparam int BIT_CLKS = 8;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              vsync_rise = 1'b0;
   logic [3:0]        div_sel = '0, sto_val = '0, eto_val = '0;
   logic              vsync_in = 1'b1, hsync_in = 1'b0, uart_rx = 1'b1, err_rd = 1'b0;
   logic [DATA_W-1:0] vid_in = '0;
   logic              vsync_out, hsync_out, ctl_en, rx_valid, err_n;
   logic [DATA_W-1:0] vid_out;
   logic [7:0]        rx_data;
   logic [1:0]        err_flags;

   int total = 0, bad = 0, cyc = 0, valid_cyc = 0, n_rx = 0;
   logic [7:0] exp_q[$];

   ctlwin_ctrl i_ctlwin_ctrl (
      .clk(clk), .rst_n(rst_n), .vsync_rise(vsync_rise), .div_sel(div_sel),
      .sto_val(sto_val), .eto_val(eto_val), .vsync_in(vsync_in), .hsync_in(hsync_in),
      .vid_in(vid_in), .uart_rx(uart_rx), .err_rd(err_rd), .vsync_out(vsync_out),
      .hsync_out(hsync_out), .vid_out(vid_out), .ctl_en(ctl_en), .rx_data(rx_data),
      .rx_valid(rx_valid), .err_flags(err_flags), .err_n(err_n));

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) if (rst_n && rx_valid) begin
      valid_cyc = cyc;
      n_rx++;
      if (exp_q.size() == 0) chk(0, "R12 unexpected byte", rx_data, -1);
      else begin
         logic [7:0] e;
         e = exp_q.pop_front();
         chk(rx_data == e, "R5 byte", rx_data, e);
      end
   end

   task automatic send_byte(input logic [7:0] b, input bit bad_par,
                            input bit bad_stop, input bit expect_it);
      logic [10:0] fr;
      if (expect_it) exp_q.push_back(b);
      fr = {~bad_stop, (^b) ^ bad_par, b, 1'b0};
      for (int i = 0; i < 11; i++) begin
         uart_rx = fr[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      uart_rx = 1'b1;
      repeat (2*BIT_CLKS) @(negedge clk);
   endtask

   task automatic count_open(input logic [DATA_W-1:0] hold_v, input logic hold_h,
                             input logic [DATA_W-1:0] new_v, output int n);
      n = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (i == 0) begin
            vid_in   = new_v;
            hsync_in = ~hold_h;
         end
         if (!ctl_en) break;
         n++;
         if (vid_out != hold_v || hsync_out != hold_h)
            chk(0, "R4 hold", vid_out, hold_v);
      end
   endtask

   task automatic wait_close(output int low_cyc);
      low_cyc = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!ctl_en) begin
            low_cyc = cyc;
            break;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, lc, rx0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ctl_en == 0 && err_n == 1 && err_flags == 0 && rx_valid == 0,
          "R1 reset flags", {ctl_en, err_n, err_flags}, 4);
      chk(vid_out == 0 && hsync_out == 0, "R1 reset video", vid_out, 0);
      rst_n = 1'b1;
      vid_in = 18'h2A5A5; hsync_in = 1'b1;
      repeat (3) @(negedge clk);
      chk(vid_out == 18'h2A5A5 && hsync_out == 1, "R4 video pass", vid_out, 18'h2A5A5);

      // R2: rising edge ignored in falling mode; R4 vsync follows
      vsync_in = 1'b0; @(negedge clk);
      vsync_in = 1'b1; @(negedge clk);
      chk(vsync_out == 1, "R4 vsync follows", vsync_out, 1);
      repeat (4) @(negedge clk);
      chk(ctl_en == 0, "R2 rising ignored", ctl_en, 0);
      // first falling edge opened window above; let it close first
      wait_close(lc);
      repeat (2) @(negedge clk);

      // R2/R7: div 1, sto 2 -> 6 cycles
      div_sel = 4'd1; sto_val = 4'd2;
      vsync_in = 1'b1; repeat (2) @(negedge clk);
      vsync_in = 1'b0;
      count_open(18'h2A5A5, 1'b1, 18'h1C3C3, n);
      chk(n == 6, "R7 start window div1 sto2", n, 6);
      chk(vsync_out == 0, "R4 vsync while open", vsync_out, 0);
      @(negedge clk);
      chk(vid_out == 18'h1C3C3 && hsync_out == 0, "R4 resume", vid_out, 18'h1C3C3);

      // R7: div 3, sto 0 -> 4 cycles
      div_sel = 4'd3; sto_val = 4'd0;
      vsync_in = 1'b1; repeat (2) @(negedge clk);
      vsync_in = 1'b0;
      count_open(18'h1C3C3, 1'b0, 18'h00F0F, n);
      chk(n == 4, "R7 start window div3 sto0", n, 4);

      // R3: rising mode
      vsync_rise = 1'b1; div_sel = 4'd0; sto_val = 4'd1;
      @(negedge clk);
      vsync_in = 1'b1; repeat (2) @(negedge clk);
      vsync_in = 1'b0; repeat (4) @(negedge clk);
      chk(ctl_en == 0, "R3 falling ignored", ctl_en, 0);
      vsync_in = 1'b1;
      count_open(18'h00F0F, 1'b1, 18'h3FFFF, n);
      chk(n == 2, "R3 rising opens", n, 2);
      vsync_rise = 1'b0;
      repeat (2) @(negedge clk);

      // R12: bytes while closed
      rx0 = n_rx;
      send_byte(8'h5A, 0, 0, 0);
      send_byte(8'h33, 1, 0, 0);
      chk(n_rx == rx0 && ctl_en == 0 && err_n == 1 && err_flags == 0,
          "R12 closed ignores", n_rx - rx0, 0);

      // long session: div 15, sto 15, eto 15
      div_sel = 4'd15; sto_val = 4'd15; eto_val = 4'd15;
      vsync_in = 1'b0; repeat (2) @(negedge clk);
      chk(ctl_en == 1, "R2 falling opens", ctl_en, 1);
      send_byte(8'h3C, 0, 0, 1);
      send_byte(8'hA5, 0, 0, 1);
      chk(n_rx == rx0 + 2, "R5 two bytes", n_rx - rx0, 2);
      send_byte(8'hFF, 1, 0, 0);
      chk(err_flags == 2'b01 && err_n == 0, "R9 parity flag", err_flags, 1);
      chk(ctl_en == 1, "R9 bad FF keeps open", ctl_en, 1);
      err_rd = 1'b1; @(negedge clk); err_rd = 1'b0; @(negedge clk);
      chk(err_flags == 0 && err_n == 1, "R11 read clears", err_flags, 0);
      send_byte(8'h81, 0, 1, 0);
      chk(err_flags == 2'b10 && err_n == 0, "R10 stop flag", err_flags, 2);
      err_rd = 1'b1; @(negedge clk); err_rd = 1'b0; @(negedge clk);
      chk(err_n == 1, "R11 err_n high", err_n, 1);
      send_byte(8'h12, 0, 0, 1);
      wait_close(lc);
      chk(lc - valid_cyc == 240, "R8 end window", lc - valid_cyc, 240);

      // R6: end byte closes
      vsync_in = 1'b1; repeat (2) @(negedge clk);
      vsync_in = 1'b0; repeat (2) @(negedge clk);
      send_byte(8'h07, 0, 0, 1);
      send_byte(8'hFF, 0, 0, 1);
      chk(ctl_en == 0, "R6 end byte closes", ctl_en, 0);
      chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule